// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Idle-State Insertion

The block runs the external bus cycles of a small bus controller. A requester hands it one access at a time. Each access names a target area, says whether it is a read or a write, says whether the area is DRAM, and gives a two-lane byte enable and an address. For each access the block drives one active-low chip select per area, a read strobe, upper and lower write strobes and a row strobe. An ordinary access takes three states, called T1, T2 and T3. A DRAM access takes four: precharge, row, then two column states. In DRAM cycles the two write-strobe pins serve as the upper and lower column strobes.

When a read is followed back to back by an access to a different area, the read strobe would release on the same clock edge that the next chip select falls. Two configuration bits can each place exactly one quiet state between such cycles, and every strobe is inactive during that state. One bit covers a read followed by a read. The other covers a read followed by a write. No quiet state is inserted for accesses to the same area, after a write, after a clock with no cycle running, or when the matching bit is clear.

Top module: `ext_bus_seq`

## Requirements
- R1: During and after reset all chip selects and strobes are high (inactive) and `req_ready_o` is 1. The first access after reset starts with no idle state.
- R2: A normal read accepted on an edge is followed by T1, T2 and T3, one clock each. The area's chip select is low in all three states. `rd_no` is low in T2 and T3 only. `addr_o` carries the request address in all three states.
- R3: A normal write runs T1, T2 and T3 with the chip select low throughout and `rd_no` high. `hwr_no` is low in T2 only and only if `req_be_i[1]` is 1. `lwr_no` is low in T2 only and only if `req_be_i[0]` is 1.
- R4: A DRAM access (`req_dram_i`=1) runs precharge, row, column 1 and column 2, with the chip select low in all four states. `ras_no` is low from the row state through column 2. `addr_o` is the upper address half, zero-extended, in precharge and row, and the lower half, zero-extended, in both column states. Both column strobes are low in the column states for a read, with `rd_no` low as well. For a write, only the lanes enabled in `req_be_i` are low.
- R5: `req_ready_o` is 1 when no cycle is running or in the last state of a cycle (T3 or column 2), and 0 otherwise. A request is taken on an edge where `req_valid_i` and `req_ready_o` are both 1. Its cycle, or its idle state, starts in the next clock.
- R6: A read followed by a read to a different area is taken on the last-state edge. If the read-read bit is 1, exactly one clock follows with every chip select and strobe high and `req_ready_o` 0, and then the next cycle begins.
- R7: A read followed by a write to a different area is taken on the last-state edge. If the read-write bit is 1, exactly one idle clock is inserted as in R6.
- R8: When the matching bit is 0, no idle state is inserted. `rd_no` rises on the same edge on which the next area's chip select falls.
- R9: No idle state is inserted when the next access targets the same area, or when the finishing cycle is a write, whatever the configuration bits are.
- R10: Both configuration bits reset to 1. They load from `cfg_rd_rd_idle_i` and `cfg_rd_wr_idle_i` on an edge where `cfg_load_i` is 1, and take effect from the next edge.
- R11: At most one chip select is low at any time, and only the one for the area of the cycle in progress.
- R12: If a clock passes with no cycle running, the next access starts with no idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_load_i | input | 1 | Load enable for the two idle-control bits |
| cfg_rd_rd_idle_i | input | 1 | New value of the read-then-read idle bit |
| cfg_rd_wr_idle_i | input | 1 | New value of the read-then-write idle bit |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request taken on this edge if valid |
| req_area_i | input | AREA_W | Target area number |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_dram_i | input | 1 | 1 = target area is DRAM |
| req_be_i | input | 2 | Byte lanes: bit 1 upper, bit 0 lower |
| req_addr_i | input | ADDR_W | Access address |
| cs_no | output | N_AREAS | Active-low chip select per area |
| rd_no | output | 1 | Active-low read strobe |
| hwr_no | output | 1 | Active-low upper write strobe / upper column strobe |
| lwr_no | output | 1 | Active-low lower write strobe / lower column strobe |
| ras_no | output | 1 | Active-low DRAM row strobe |
| addr_o | output | ADDR_W | Address bus |

## Verification
Every output is registered from the next-state decode. The first state of an accepted access, or its idle state, therefore appears in the clock period that begins at the accepting edge, and each later state follows one period after the last. `req_ready_o` is decoded from the current state and reflects the same period. For each accepted request the bench pushes one expected output word per clock into a queue and pops one word 3 ns after every rising edge. When the queue is empty it expects the quiet no-cycle word, so an idle state that is missing or added shifts every following word and is reported. The bench decides whether an idle state is due from its own record of the previous access, the configuration it wrote, and whether the previous cycle's last state was the word just popped.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    typedef enum logic [3:0] {
        ST_NONE,
        ST_TI,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TP,
        ST_TR,
        ST_TC1,
        ST_TC2
    } ebs_state_e;

    // strobe activity of one bus state, independent of request fields
    typedef struct packed {
        logic sel;      // chip select active
        logic rd_win;   // read strobe window
        logic wr_win;   // normal write strobe window
        logic cas_win;  // DRAM column strobe window
        logic ras_win;  // DRAM row strobe window
        logic row_adr;  // drive row half
        logic col_adr;  // drive column half
    } ebs_phase_t;

    function automatic logic ebs_is_last(ebs_state_e s);
        return (s == ST_T3) || (s == ST_TC2);
    endfunction

    function automatic ebs_phase_t ebs_phase(ebs_state_e s);
        ebs_phase_t p;
        p = '0;
        case (s)
            ST_T1:  p.sel = 1'b1;
            ST_T2:  begin p.sel = 1'b1; p.rd_win = 1'b1; p.wr_win = 1'b1; end
            ST_T3:  begin p.sel = 1'b1; p.rd_win = 1'b1; end
            ST_TP:  begin p.sel = 1'b1; p.row_adr = 1'b1; end
            ST_TR:  begin p.sel = 1'b1; p.row_adr = 1'b1; p.ras_win = 1'b1; end
            ST_TC1, ST_TC2: begin
                p.sel = 1'b1; p.col_adr = 1'b1; p.ras_win = 1'b1;
                p.cas_win = 1'b1; p.rd_win = 1'b1;
            end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/ebs_idle_rule.sv
module ebs_idle_rule #(
    parameter int AREA_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_load_i,
    input  logic              cfg_rd_rd_idle_i,
    input  logic              cfg_rd_wr_idle_i,
    input  logic              cur_last_i,
    input  logic              cur_write_i,
    input  logic [AREA_W-1:0] cur_area_i,
    input  logic              new_write_i,
    input  logic [AREA_W-1:0] new_area_i,
    output logic              insert_o
);

    typedef struct packed {
        logic rd_rd;
        logic rd_wr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_load_i) begin
            cfg_d.rd_rd = cfg_rd_rd_idle_i;
            cfg_d.rd_wr = cfg_rd_wr_idle_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '{rd_rd: 1'b1, rd_wr: 1'b1};
        else         cfg_q <= cfg_d;
    end

    logic area_change;
    logic kind_enabled;

    always_comb begin
        area_change  = (cur_area_i != new_area_i);
        kind_enabled = new_write_i ? cfg_q.rd_wr : cfg_q.rd_rd;
        insert_o     = cur_last_i && !cur_write_i && area_change && kind_enabled;
    end

endmodule

// File: rtl/ebs_seq.sv
module ebs_seq
    import ebs_pkg::*;
#(
    parameter int AREA_W = 3,
    parameter int ADDR_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [AREA_W-1:0] req_area_i,
    input  logic              req_write_i,
    input  logic              req_dram_i,
    input  logic [1:0]        req_be_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              insert_i,
    output logic              ready_o,
    output logic              last_o,
    output ebs_state_e        state_q_o,
    output ebs_state_e        state_d_o,
    output logic [AREA_W-1:0] area_q_o,
    output logic              write_q_o,
    output logic [AREA_W-1:0] area_d_o,
    output logic              write_d_o,
    output logic [1:0]        be_d_o,
    output logic [ADDR_W-1:0] addr_d_o
);

    typedef struct packed {
        ebs_state_e        state;
        logic [AREA_W-1:0] area;
        logic              write;
        logic              dram;
        logic [1:0]        be;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t       seq_d, seq_q;
    logic       fire;
    ebs_state_e first_st;

    always_comb begin
        ready_o = (seq_q.state == ST_NONE) || ebs_is_last(seq_q.state);
        last_o  = ebs_is_last(seq_q.state);
    end

    always_comb begin
        seq_d    = seq_q;
        fire     = req_valid_i && ready_o;
        first_st = insert_i ? ST_TI : (req_dram_i ? ST_TP : ST_T1);
        case (seq_q.state)
            ST_NONE: seq_d.state = ST_NONE;
            ST_TI:   seq_d.state = seq_q.dram ? ST_TP : ST_T1;
            ST_T1:   seq_d.state = ST_T2;
            ST_T2:   seq_d.state = ST_T3;
            ST_TP:   seq_d.state = ST_TR;
            ST_TR:   seq_d.state = ST_TC1;
            ST_TC1:  seq_d.state = ST_TC2;
            default: seq_d.state = ST_NONE;
        endcase
        if (fire) begin
            seq_d.state = first_st;
            seq_d.area  = req_area_i;
            seq_d.write = req_write_i;
            seq_d.dram  = req_dram_i;
            seq_d.be    = req_be_i;
            seq_d.addr  = req_addr_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q       <= '0;
            seq_q.state <= ST_NONE;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        state_q_o = seq_q.state;
        state_d_o = seq_d.state;
        area_q_o  = seq_q.area;
        write_q_o = seq_q.write;
        area_d_o  = seq_d.area;
        write_d_o = seq_d.write;
        be_d_o    = seq_d.be;
        addr_d_o  = seq_d.addr;
    end

    // an idle state only ever follows the last state of a read
    p_idle_after_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.state == ST_TI) |-> ($past(ebs_is_last(seq_q.state)) && !$past(seq_q.write)));

    // captured request fields hold while the block is not ready
    p_request_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.state != ST_NONE && !$past(ready_o)) |-> ($stable(seq_q.addr) && $stable(seq_q.area)));

endmodule

// File: rtl/ebs_strobe.sv
module ebs_strobe
    import ebs_pkg::*;
#(
    parameter int N_AREAS = 8,
    parameter int ADDR_W  = 16,
    localparam int AREA_W = $clog2(N_AREAS),
    localparam int HALF_W = ADDR_W / 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  ebs_state_e        state_d_i,
    input  ebs_state_e        state_q_i,
    input  logic [AREA_W-1:0] area_d_i,
    input  logic              write_d_i,
    input  logic [1:0]        be_d_i,
    input  logic [ADDR_W-1:0] addr_d_i,
    output logic [N_AREAS-1:0] cs_no,
    output logic              rd_no,
    output logic              hwr_no,
    output logic              lwr_no,
    output logic              ras_no,
    output logic [ADDR_W-1:0] addr_o
);

    typedef struct packed {
        logic [N_AREAS-1:0] cs_n;
        logic               rd_n;
        logic               hwr_n;
        logic               lwr_n;
        logic               ras_n;
        logic [ADDR_W-1:0]  addr;
    } pins_t;

    pins_t      pins_d, pins_q;
    ebs_phase_t ph;
    logic [N_AREAS-1:0] cs_n_d;

    assign ph = ebs_phase(state_d_i);

    for (genvar g = 0; g < N_AREAS; g++) begin : g_cs
        assign cs_n_d[g] = !(ph.sel && (area_d_i == AREA_W'(g)));
    end

    always_comb begin
        pins_d       = pins_q;
        pins_d.cs_n  = cs_n_d;
        pins_d.rd_n  = !(ph.rd_win && !write_d_i);
        pins_d.ras_n = !ph.ras_win;
        pins_d.hwr_n = !((ph.wr_win && write_d_i && be_d_i[1]) ||
                         (ph.cas_win && (!write_d_i || be_d_i[1])));
        pins_d.lwr_n = !((ph.wr_win && write_d_i && be_d_i[0]) ||
                         (ph.cas_win && (!write_d_i || be_d_i[0])));
        if (ph.row_adr)      pins_d.addr = ADDR_W'(addr_d_i[ADDR_W-1:HALF_W]);
        else if (ph.col_adr) pins_d.addr = ADDR_W'(addr_d_i[HALF_W-1:0]);
        else if (ph.sel)     pins_d.addr = addr_d_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pins_q      <= '0;
            pins_q.cs_n <= '1;
            pins_q.rd_n <= 1'b1;
            pins_q.hwr_n <= 1'b1;
            pins_q.lwr_n <= 1'b1;
            pins_q.ras_n <= 1'b1;
        end else begin
            pins_q <= pins_d;
        end
    end

    always_comb begin
        cs_no  = pins_q.cs_n;
        rd_no  = pins_q.rd_n;
        hwr_no = pins_q.hwr_n;
        lwr_no = pins_q.lwr_n;
        ras_no = pins_q.ras_n;
        addr_o = pins_q.addr;
    end

    p_single_select_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~cs_no));

    p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q_i == ST_TI) |-> ((&cs_no) && rd_no && hwr_no && lwr_no && ras_no));

    p_row_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q_i == ST_TC2) |-> (!ras_no && $past(!ras_no)));

    p_read_write_apart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((!hwr_no || !lwr_no) && !rd_no) |-> !ras_no);

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ebs_pkg::*;
#(
    parameter int N_AREAS = 8,
    parameter int ADDR_W  = 16,
    localparam int AREA_W = $clog2(N_AREAS)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cfg_load_i,
    input  logic               cfg_rd_rd_idle_i,
    input  logic               cfg_rd_wr_idle_i,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic [AREA_W-1:0]  req_area_i,
    input  logic               req_write_i,
    input  logic               req_dram_i,
    input  logic [1:0]         req_be_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    output logic [N_AREAS-1:0] cs_no,
    output logic               rd_no,
    output logic               hwr_no,
    output logic               lwr_no,
    output logic               ras_no,
    output logic [ADDR_W-1:0]  addr_o
);

    logic              insert;
    logic              cur_last;
    ebs_state_e        state_q, state_d;
    logic [AREA_W-1:0] area_q, area_d;
    logic              write_q, write_d;
    logic [1:0]        be_d;
    logic [ADDR_W-1:0] addr_d;

    ebs_idle_rule #(.AREA_W(AREA_W)) u_rule (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .cfg_load_i      (cfg_load_i),
        .cfg_rd_rd_idle_i(cfg_rd_rd_idle_i),
        .cfg_rd_wr_idle_i(cfg_rd_wr_idle_i),
        .cur_last_i      (cur_last),
        .cur_write_i     (write_q),
        .cur_area_i      (area_q),
        .new_write_i     (req_write_i),
        .new_area_i      (req_area_i),
        .insert_o        (insert)
    );

    ebs_seq #(.AREA_W(AREA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_valid_i(req_valid_i),
        .req_area_i (req_area_i),
        .req_write_i(req_write_i),
        .req_dram_i (req_dram_i),
        .req_be_i   (req_be_i),
        .req_addr_i (req_addr_i),
        .insert_i   (insert),
        .ready_o    (req_ready_o),
        .last_o     (cur_last),
        .state_q_o  (state_q),
        .state_d_o  (state_d),
        .area_q_o   (area_q),
        .write_q_o  (write_q),
        .area_d_o   (area_d),
        .write_d_o  (write_d),
        .be_d_o     (be_d),
        .addr_d_o   (addr_d)
    );

    ebs_strobe #(.N_AREAS(N_AREAS), .ADDR_W(ADDR_W)) u_strobe (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .state_d_i(state_d),
        .state_q_i(state_q),
        .area_d_i (area_d),
        .write_d_i(write_d),
        .be_d_i   (be_d),
        .addr_d_i (addr_d),
        .cs_no    (cs_no),
        .rd_no    (rd_no),
        .hwr_no   (hwr_no),
        .lwr_no   (lwr_no),
        .ras_no   (ras_no),
        .addr_o   (addr_o)
    );

endmodule

// File: tb/ext_bus_seq_tb.sv
module ext_bus_seq_tb;

    localparam int N  = 8;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0, cfg_rr = 1'b0, cfg_rw = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_area = '0;
    logic          req_write = 1'b0, req_dram = 1'b0;
    logic [1:0]    req_be = '0;
    logic [AW-1:0] req_addr = '0;
    logic [N-1:0]  cs_n;
    logic          rd_n, hwr_n, lwr_n, ras_n;
    logic [AW-1:0] addr;

    always #5 clk = ~clk;

    ext_bus_seq #(.N_AREAS(N), .ADDR_W(AW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_load_i(cfg_load), .cfg_rd_rd_idle_i(cfg_rr), .cfg_rd_wr_idle_i(cfg_rw),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_area_i(req_area), .req_write_i(req_write), .req_dram_i(req_dram),
        .req_be_i(req_be), .req_addr_i(req_addr),
        .cs_no(cs_n), .rd_no(rd_n), .hwr_no(hwr_n), .lwr_no(lwr_n),
        .ras_no(ras_n), .addr_o(addr)
    );

    typedef struct packed {
        logic [N-1:0]  cs;
        logic          rd, hwr, lwr, ras, rdy;
        logic          achk;
        logic [AW-1:0] adr;
        logic          fin;
        logic [7:0]    tag;
    } exp_t;

    exp_t sb_q[$];
    int   vectors = 0;
    int   misses  = 0;
    int   cyc     = 0;
    bit   last_pop_final = 1'b0;
    bit   m_rr = 1'b1, m_rw = 1'b1;  // R10: reset values of the idle bits
    bit   m_wr = 1'b0, had_any = 1'b0;
    int   m_area = 0;

    function automatic exp_t quiet_item();
        exp_t e;
        e = '0;
        e.cs = '1; e.rd = 1; e.hwr = 1; e.lwr = 1; e.ras = 1; e.rdy = 1;
        e.tag = 8'd5;  // R5: no cycle running, ready high
        return e;
    endfunction

    // ph: 0 idle, 1..3 normal states, 4 precharge, 5 row, 6/7 column
    function automatic exp_t cyc_item(int ph, int area, bit wr, logic [1:0] be,
                                      logic [AW-1:0] a, int tag);
        exp_t e;
        e = '0;
        e.cs   = (ph == 0) ? '1 : ~(N'(1) << area);
        e.rd   = !(!wr && (ph == 2 || ph == 3 || ph >= 6));
        e.hwr  = !((ph == 2 && wr && be[1]) || (ph >= 6 && (!wr || be[1])));
        e.lwr  = !((ph == 2 && wr && be[0]) || (ph >= 6 && (!wr || be[0])));
        e.ras  = !(ph >= 5);
        e.rdy  = (ph == 3 || ph == 7);
        e.fin  = e.rdy;
        e.achk = (ph != 0);
        if (ph >= 1 && ph <= 3)      e.adr = a;
        else if (ph == 4 || ph == 5) e.adr = {8'h00, a[15:8]};
        else                         e.adr = {8'h00, a[7:0]};
        e.tag  = 8'(tag);
        return e;
    endfunction

    task automatic send(input int area, input bit wr, input bit dram,
                        input logic [1:0] be, input logic [AW-1:0] a);
        bit prev_act, ins;
        int base, first_tag, ph0, nph;
        req_area = 3'(area); req_write = wr; req_dram = dram;
        req_be = be; req_addr = a; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        prev_act = last_pop_final;
        ins  = prev_act && !m_wr && (m_area != area) && (wr ? m_rw : m_rr);
        base = dram ? 4 : (wr ? 3 : 2);           // R4 / R3 / R2
        if (ins)             first_tag = base;
        else if (!prev_act)  first_tag = had_any ? 12 : 1;  // R12 gap, R1 first
        else if (!m_wr && m_area != area) first_tag = 8;    // R8 bit cleared
        else                 first_tag = 9;                 // R9 same area / after write
        if (ins) sb_q.push_back(cyc_item(0, area, wr, be, a, wr ? 7 : 6)); // R7 / R6
        ph0 = dram ? 4 : 1;
        nph = dram ? 4 : 3;
        for (int k = 0; k < nph; k++)
            sb_q.push_back(cyc_item(ph0 + k, area, wr, be, a, (k == 0) ? first_tag : base));
        m_wr = wr; m_area = area; had_any = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_cfg(input bit rr, input bit rw);
        cfg_load = 1'b1; cfg_rr = rr; cfg_rw = rw;
        @(negedge clk);
        cfg_load = 1'b0;
        m_rr = rr; m_rw = rw;  // R10: loaded value applies from the next edge
    endtask

    task automatic gap(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    // monitor: one expected word per clock, sampled 3 ns after the rising edge
    initial begin
        exp_t e;
        wait (rst_n);
        forever begin
            @(posedge clk);
            #3;
            if (sb_q.size() > 0) e = sb_q.pop_front();
            else                 e = quiet_item();
            vectors++;
            // R11: the whole chip-select vector is compared, one low bit at most
            if ({cs_n, rd_n, hwr_n, lwr_n, ras_n, req_ready} !==
                {e.cs, e.rd, e.hwr, e.lwr, e.ras, e.rdy} ||
                (e.achk && addr !== e.adr)) begin
                misses++;
                $display("FAIL R%0d cycle %0d: got cs=%b rd=%b hwr=%b lwr=%b ras=%b rdy=%b addr=%h exp cs=%b rd=%b hwr=%b lwr=%b ras=%b rdy=%b addr=%h(chk %b)",
                         e.tag, cyc, cs_n, rd_n, hwr_n, lwr_n, ras_n, req_ready, addr,
                         e.cs, e.rd, e.hwr, e.lwr, e.ras, e.rdy, e.adr, e.achk);
            end
            last_pop_final = e.fin;
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        repeat (20000) @(posedge clk);
        misses++;
        $display("FAIL R5 watchdog expired at cycle %0d: got hung run, exp completion", cyc);
        summary();
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #3;
        vectors++;  // R1: strobes inactive and ready high while in reset
        if ({cs_n, rd_n, hwr_n, lwr_n, ras_n, req_ready} !== {{N{1'b1}}, 5'b11111}) begin
            misses++;
            $display("FAIL R1 reset: got %b exp %b",
                     {cs_n, rd_n, hwr_n, lwr_n, ras_n, req_ready}, {{N{1'b1}}, 5'b11111});
        end
        @(negedge clk);
        rst_n = 1'b1;
        gap(3);
        // default bits (R10): read then read/write to other areas get an idle
        send(1, 0, 0, 2'b11, 16'h1234);   // R1 first access, no idle
        send(2, 0, 0, 2'b11, 16'h2345);   // R6
        send(5, 1, 0, 2'b11, 16'h3456);   // R7
        send(5, 0, 0, 2'b11, 16'h4567);   // R9 after write
        send(5, 0, 0, 2'b11, 16'h5678);   // R9 same area
        send(3, 0, 1, 2'b11, 16'hA1B2);   // R4 DRAM read, R6 idle
        send(4, 1, 1, 2'b01, 16'hC3D4);   // R4 DRAM write lower lane, R7 idle
        send(4, 1, 1, 2'b10, 16'hE5F6);   // R4 upper lane, R9
        gap(2);
        set_cfg(0, 0);
        send(1, 0, 0, 2'b11, 16'h0101);
        send(2, 0, 0, 2'b11, 16'h0202);   // R8 read-read, bit clear
        send(6, 1, 0, 2'b10, 16'h0303);   // R8 read-write, bit clear; R3 upper only
        send(0, 1, 0, 2'b01, 16'h0404);   // R9 after write; R3 lower only
        gap(1);
        set_cfg(1, 0);
        send(1, 0, 0, 2'b11, 16'h1111);
        send(2, 1, 0, 2'b11, 16'h2222);   // R8 read-write bit clear
        send(3, 0, 0, 2'b11, 16'h3333);   // R9 after write
        send(0, 0, 0, 2'b11, 16'h4444);   // R6 read-read bit set
        gap(1);
        set_cfg(0, 1);
        send(0, 0, 1, 2'b11, 16'h5555);
        send(7, 0, 0, 2'b11, 16'h6666);   // R8 read-read bit clear
        send(2, 1, 1, 2'b00, 16'h7777);   // R7 read-write bit set, no lanes
        gap(1);
        set_cfg(1, 1);
        send(1, 0, 0, 2'b11, 16'h8888);
        gap(1);
        send(2, 0, 0, 2'b11, 16'h9999);   // R12 gap clears the record
        while (sb_q.size() > 0) @(negedge clk);
        gap(3);
        summary();
        $finish;
    end

endmodule